// File: doc/BRIEF.md
# Timer Capture Unit with Byte-Read Interlock

This block holds two 16-bit snapshot registers next to a free-running timer count. Register 0 loads the count on a selected hardware trigger edge or when software writes zero to the capture-command bit. Register 1 loads it on a selected hardware trigger edge only. A 2-bit timing mode chooses which trigger edges load which register. Every load produces a one-cycle pulse, which the output flip-flop logic uses. Capture of either kind works only while the prescaler run input is high.

Software reads a register through a combinational read port, as one 16-bit access or as two 8-bit accesses (low byte, then high byte). A small interlock state machine protects the byte-pair read from tearing. It has three states: `LK_OPEN` (capture allowed), `LK_HOLD0` and `LK_HOLD1` (capture frozen after a low-byte read of register 0 or register 1). Four transitions exist. A low-byte read in `LK_OPEN` moves to `LK_HOLD0` or `LK_HOLD1` according to the register read. A high-byte read of the same register returns from `LK_HOLD0` or `LK_HOLD1` to `LK_OPEN`. Every other access, and every change of the run input, keeps the current state. The freeze also applies in the same cycle as the low-byte read, so the high byte always comes from the same snapshot as the low byte.

Top module: `cap_lock_unit`

## Requirements
- R1: After reset both capture registers read 0x0000. A load stores the `count` value present at the loading clock edge. A 16-bit read (`rd_wide`=1) returns the whole value of the register chosen by `rd_sel`.
- R2: A cycle with `swcap_wr`=1 and `swcap_val`=0 loads register 0 when capture is allowed. A write with `swcap_val`=1 loads nothing.
- R3: `mode` selects the hardware loads. 00 means no hardware loads. 01 means a rising `trig[0]` loads register 0 and a rising `trig[1]` loads register 1. 10 means a rising `trig[0]` loads register 0 and a falling `trig[0]` loads register 1. 11 means a rising `trig[1]` loads register 0 and a falling `trig[1]` loads register 1.
- R4: Triggers are edge-detected. A level held high causes no further loads. An edge that arrives while capture is frozen is dropped and is not replayed after the freeze ends.
- R5: A byte read (`rd_wide`=0) returns the low byte (`rd_upper`=0) or the high byte (`rd_upper`=1) on `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R6: A low-byte read of either register freezes loading of both registers, starting in that same cycle. Only a later high-byte read of the same register releases the freeze. A high-byte read of the other register does not release it.
- R7: The freeze persists through `run` going low and back high.
- R8: While `run`=0 no register loads.
- R9: `cap_pulse[k]` is high for exactly the one cycle after each clock edge on which register k loaded.
- R10: A 16-bit read does not change the freeze state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Prescaler running; capture allowed only when high |
| count | input | 16 | Up-counter value |
| trig | input | 2 | Synchronized hardware trigger levels |
| mode | input | 2 | Capture timing mode |
| swcap_wr | input | 1 | Write strobe for the software capture bit |
| swcap_val | input | 1 | Value written; 0 commands a capture into register 0 |
| rd_en | input | 1 | Read access this cycle |
| rd_sel | input | 1 | Register selected for the read |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = byte read |
| rd_upper | input | 1 | For byte reads, 1 = high byte |
| rd_data | output | 16 | Read data (combinational) |
| cap_pulse | output | 2 | One-cycle load pulse per register |

## Verification
Read data is combinational, so each expected read value is pushed into the scoreboard while the access is held and compared before the next rising edge. A load takes place on the rising edge that follows a trigger edge or a software command. The new value and `cap_pulse` are then visible at the next falling edge, so the bench samples pulses there, one falling edge after driving. The bench samples again one edge later to confirm each pulse has dropped. A freeze from a low-byte read applies in the cycle of the read, so a capture driven in the cycle after it must give no pulse.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        LK_OPEN  = 2'd0,
        LK_HOLD0 = 2'd1,
        LK_HOLD1 = 2'd2
    } lock_state_e;

    typedef enum logic [1:0] {
        CM_OFF     = 2'd0,
        CM_SPLIT   = 2'd1,
        CM_T0_BOTH = 2'd2,
        CM_T1_BOTH = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
    parameter int NTRIG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig,
    output logic [NTRIG-1:0] rise,
    output logic [NTRIG-1:0] fall
);
    logic [NTRIG-1:0] prev_q;

    for (genvar i = 0; i < NTRIG; i++) begin : g_det
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= trig[i];
        end
        assign rise[i] = trig[i] & ~prev_q[i];
        assign fall[i] = ~trig[i] & prev_q[i];
    end
endmodule

// File: rtl/cap_lock_fsm.sv
module cap_lock_fsm
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic rd_sel,
    input  logic rd_wide,
    input  logic rd_upper,
    output logic locked,
    output logic freeze
);
    lock_state_e state_q, state_d;
    logic lo_read, hi_read;

    assign lo_read = rd_en & ~rd_wide & ~rd_upper;
    assign hi_read = rd_en & ~rd_wide &  rd_upper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:  if (lo_read) state_d = rd_sel ? LK_HOLD1 : LK_HOLD0;
            LK_HOLD0: if (hi_read && !rd_sel) state_d = LK_OPEN;
            LK_HOLD1: if (hi_read &&  rd_sel) state_d = LK_OPEN;
            default:  state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        locked = (state_q != LK_OPEN);
        freeze = locked | lo_read;
    end
endmodule

// File: rtl/cap_bank.sv
module cap_bank #(
    parameter int CNT_W = 16,
    parameter int NREG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [NREG-1:0]  load,
    output logic [CNT_W-1:0] val [NREG],
    output logic [NREG-1:0]  pulse
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val[k]   <= '0;
                pulse[k] <= 1'b0;
            end else begin
                if (load[k]) val[k] <= count;
                pulse[k] <= load[k];
            end
        end
    end
endmodule

// File: rtl/cap_lock_unit.sv
module cap_lock_unit
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       trig,
    input  logic [1:0]       mode,
    input  logic             swcap_wr,
    input  logic             swcap_val,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic             rd_wide,
    input  logic             rd_upper,
    output logic [CNT_W-1:0] rd_data,
    output logic [1:0]       cap_pulse
);
    localparam int HALF_W = CNT_W / 2;
    localparam int NREG   = 2;

    logic [1:0]       rise, fall;
    logic             lock_active, freeze;
    logic             hw0, hw1, sw_cmd, cap_ok;
    logic [NREG-1:0]  load;
    logic [CNT_W-1:0] val [NREG];
    logic [CNT_W-1:0] val0, val1, sel_val;

    cap_edge_det #(.NTRIG(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .trig(trig), .rise(rise), .fall(fall)
    );

    cap_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_wide(rd_wide), .rd_upper(rd_upper),
        .locked(lock_active), .freeze(freeze)
    );

    always_comb begin
        hw0 = 1'b0;
        hw1 = 1'b0;
        unique case (cap_mode_e'(mode))
            CM_OFF:     ;
            CM_SPLIT:   begin hw0 = rise[0]; hw1 = rise[1]; end
            CM_T0_BOTH: begin hw0 = rise[0]; hw1 = fall[0]; end
            CM_T1_BOTH: begin hw0 = rise[1]; hw1 = fall[1]; end
            default:    ;
        endcase
    end

    assign sw_cmd  = swcap_wr & ~swcap_val;
    assign cap_ok  = run & ~freeze;
    assign load[0] = cap_ok & (hw0 | sw_cmd);
    assign load[1] = cap_ok & hw1;

    cap_bank #(.CNT_W(CNT_W), .NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .count(count), .load(load),
        .val(val), .pulse(cap_pulse)
    );

    assign val0    = val[0];
    assign val1    = val[1];
    assign sel_val = rd_sel ? val1 : val0;

    always_comb begin
        if (rd_wide)       rd_data = sel_val;
        else if (rd_upper) rd_data = {{HALF_W{1'b0}}, sel_val[CNT_W-1:HALF_W]};
        else               rd_data = {{HALF_W{1'b0}}, sel_val[HALF_W-1:0]};
    end
endmodule

// File: rtl/cap_lock_chk.sv
module cap_lock_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic             swcap_wr,
    input logic             swcap_val,
    input logic             rd_en,
    input logic             rd_wide,
    input logic             rd_upper,
    input logic             lock_active,
    input logic [CNT_W-1:0] val0,
    input logic [1:0]       cap_pulse
);
    AST_PULSE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse[0] |-> (val0 == $past(count))) else $error("pulse value"); // R1
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !lock_active && swcap_wr && !swcap_val && !(rd_en && !rd_wide && !rd_upper))
        |=> cap_pulse[0]) else $error("sw load"); // R2
    AST_NO_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cap_pulse == 2'b00)) else $error("run low load"); // R8
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> (cap_pulse == 2'b00)) else $error("frozen load"); // R6
    AST_WORD_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && rd_en && rd_wide) |=> lock_active) else $error("word unlock"); // R10
    AST_STOP_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !run && !(rd_en && !rd_wide)) |=> lock_active) else $error("stop unlock"); // R7
endmodule

bind cap_lock_unit cap_lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .count(count),
    .swcap_wr(swcap_wr), .swcap_val(swcap_val), .rd_en(rd_en),
    .rd_wide(rd_wide), .rd_upper(rd_upper), .lock_active(lock_active),
    .val0(val0), .cap_pulse(cap_pulse)
);

// File: tb/tb_cap_lock_unit.sv
module tb_cap_lock_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] count = '0;
    logic [1:0]  trig = '0;
    logic [1:0]  mode = '0;
    logic        swcap_wr = 1'b0, swcap_val = 1'b1;
    logic        rd_en = 1'b0, rd_sel = 1'b0, rd_wide = 1'b0, rd_upper = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  cap_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    cap_lock_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: compares the read port against queued expectations
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic do_read(input bit sel, input bit wide, input bit upper,
                           input logic [15:0] exp, input string tag);
        rd_en = 1'b1; rd_sel = sel; rd_wide = wide; rd_upper = upper;
        #(CLK_PERIOD/4);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " pulse-after-read"}, {14'd0, cap_pulse}, 16'd0);
    endtask

    task automatic sw_cap(input logic [15:0] k, input bit expect_pulse, input string tag);
        count = k; swcap_wr = 1'b1; swcap_val = 1'b0;
        @(negedge clk);
        swcap_wr = 1'b0; swcap_val = 1'b1;
        check({tag, " pulse0"}, {15'd0, cap_pulse[0]}, {15'd0, expect_pulse});
        @(negedge clk);
        check({tag, " pulse drop R9"}, {14'd0, cap_pulse}, 16'd0);
    endtask

    task automatic trig_set(input logic [1:0] t, input logic [15:0] k,
                            input logic [1:0] exp_p, input string tag);
        count = k; trig = t;
        @(negedge clk);
        check({tag, " pulses"}, {14'd0, cap_pulse}, {14'd0, exp_p});
        @(negedge clk);
        check({tag, " pulse drop R9"}, {14'd0, cap_pulse}, 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset pulses", {14'd0, cap_pulse}, 16'd0);
        do_read(0, 1, 0, 16'h0000, "R1 reset reg0");
        do_read(1, 1, 0, 16'h0000, "R1 reset reg1");
        // R8 no capture while stopped
        sw_cap(16'h1111, 1'b0, "R8 stopped");
        do_read(0, 1, 0, 16'h0000, "R8 reg0 unchanged");
        run = 1'b1;
        // R2 software capture, R9 pulse
        sw_cap(16'h1234, 1'b1, "R2 swcap");
        do_read(0, 1, 0, 16'h1234, "R2 reg0 value");
        count = 16'h5555; swcap_wr = 1'b1; swcap_val = 1'b1;
        @(negedge clk);
        swcap_wr = 1'b0;
        check("R2 write one no pulse", {14'd0, cap_pulse}, 16'd0);
        do_read(0, 1, 0, 16'h1234, "R2 write one ignored");
        // R3 mode 01, R4 held level
        mode = 2'b01;
        trig_set(2'b10, 16'hA0A0, 2'b10, "R3 m01 trig1");
        trig_set(2'b10, 16'hBBBB, 2'b00, "R4 held level");
        do_read(1, 1, 0, 16'hA0A0, "R4 reg1 kept");
        trig_set(2'b00, 16'hBBBB, 2'b00, "R3 m01 trig1 fall");
        trig_set(2'b01, 16'h0C0C, 2'b01, "R3 m01 trig0");
        trig_set(2'b00, 16'h0C0D, 2'b00, "R3 m01 trig0 fall");
        do_read(0, 1, 0, 16'h0C0C, "R3 m01 reg0");
        // mode 10
        mode = 2'b10;
        trig_set(2'b01, 16'h2222, 2'b01, "R3 m10 rise");
        trig_set(2'b00, 16'h3333, 2'b10, "R3 m10 fall");
        do_read(0, 1, 0, 16'h2222, "R3 m10 reg0");
        do_read(1, 1, 0, 16'h3333, "R3 m10 reg1");
        // mode 11
        mode = 2'b11;
        trig_set(2'b10, 16'h4444, 2'b01, "R3 m11 rise");
        trig_set(2'b00, 16'h5656, 2'b10, "R3 m11 fall");
        do_read(0, 1, 0, 16'h4444, "R3 m11 reg0");
        do_read(1, 1, 0, 16'h5656, "R3 m11 reg1");
        // mode 00
        mode = 2'b00;
        trig_set(2'b01, 16'h7777, 2'b00, "R3 m00 rise");
        trig_set(2'b00, 16'h7778, 2'b00, "R3 m00 fall");
        // R5 / R6 byte reads and freeze
        do_read(0, 0, 0, 16'h0044, "R5 low byte reg0");
        sw_cap(16'h9999, 1'b0, "R6 frozen");
        do_read(1, 0, 1, 16'h0056, "R5 high byte reg1");
        sw_cap(16'h9998, 1'b0, "R6 other high no release");
        do_read(0, 0, 1, 16'h0044, "R5 high byte reg0");
        sw_cap(16'h8888, 1'b1, "R6 released");
        do_read(0, 1, 0, 16'h8888, "R6 reg0 after release");
        // R7 freeze survives stop/restart, R10 word read keeps freeze
        do_read(1, 0, 0, 16'h0056, "R7 low byte reg1");
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        sw_cap(16'h6161, 1'b0, "R7 frozen after restart");
        do_read(1, 1, 0, 16'h5656, "R10 word read");
        sw_cap(16'h6262, 1'b0, "R10 still frozen");
        do_read(1, 0, 1, 16'h0056, "R7 high byte reg1");
        sw_cap(16'h6363, 1'b1, "R7 released");
        // R4 edge during freeze dropped
        mode = 2'b01;
        do_read(0, 0, 0, 16'h0063, "R4 low byte reg0");
        trig_set(2'b10, 16'h7070, 2'b00, "R4 edge while frozen");
        do_read(0, 0, 1, 16'h0063, "R4 high byte reg0");
        @(negedge clk);
        check("R4 dropped edge not replayed", {14'd0, cap_pulse}, 16'd0);
        do_read(1, 1, 0, 16'h5656, "R4 reg1 unchanged");
        trig = 2'b00;
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule